// File: doc/BRIEF.md
# Periodic Self-Trigger Generator

This block produces an internal trigger strobe at a rate that software sets. A trigger system can then be exercised without any detector signal. Software programs a 28-bit period, counted in clock ticks. At 100 MHz one tick is 10 ns, so the strobe rate is 1/(period × 10 ns). A period of zero turns the generator fully off. Any nonzero period turns it on, and the status output shows which of the two is in effect.

The same strobe train also drives a second output for trigger-line testing. That output is gated by its own enable bit, so the line test always runs at the programmed rate. Each write of a period restarts the internal count, whether or not the value changes. The first strobe after a write therefore comes one full new period later.

Top module: `self_trig_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no write yet, trig_o, line_test_o and active_o are all 0.
- R2: When the programmed period is 0, trig_o and line_test_o stay 0 and active_o is 0.
- R3: A write (period_we_i high at a rising edge) stores period_i. From the next cycle, active_o is 1 exactly when the stored value is nonzero. This holds up to the full 28-bit value 0xFFFFFFF.
- R4: With a stored period P ≥ 1, trig_o is seen high at the P-th rising edge after the write edge, and then at every P-th edge after that.
- R5: For P ≥ 2 each strobe lasts exactly one clock cycle. For P = 1, trig_o is high on every cycle.
- R6: line_test_o equals trig_o while line_test_en_i is 1, and is 0 while line_test_en_i is 0.
- R7: A write restarts the count even when it repeats the current value. No strobe from the old count appears after the write.
- R8: A write landing on a strobe cycle leaves that strobe intact. The next strobe then follows the newly written period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 28 | Period value in clock ticks; 0 disables the generator |
| period_we_i | input | 1 | Write strobe for period_i |
| line_test_en_i | input | 1 | Enable for the trigger-line test output |
| trig_o | output | 1 | One-cycle trigger strobe |
| line_test_o | output | 1 | Strobe train gated by line_test_en_i |
| active_o | output | 1 | High while a nonzero period is stored |

## Verification
Two events can fall in the same cycle: a period write and a strobe that is due from the running count. The bench provokes this by waiting until it sees trig_o high. On that same cycle it drives a write of a different period. It then judges two things: the strobe in that cycle was emitted, and the next strobe comes exactly the new period later, not at the old spacing.

// File: rtl/stg_pkg.sv
package stg_pkg;
  parameter int unsigned STG_PERIOD_W = 28;
endpackage

// File: rtl/stg_period_reg.sv
module stg_period_reg #(
  parameter int unsigned W = stg_pkg::STG_PERIOD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] period_o,
  output logic         active_o
);
  logic [W-1:0] period_q;
  logic         active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      active_q <= 1'b0;
    end else if (we_i) begin
      period_q <= val_i;
      active_q <= (val_i != '0);
    end
  end

  assign period_o = period_q;
  assign active_o = active_q;
endmodule

// File: rtl/stg_tick_counter.sv
module stg_tick_counter #(
  parameter int unsigned W = stg_pkg::STG_PERIOD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         active_i,
  input  logic [W-1:0] period_i,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] last_idx;

  assign last_idx = period_i - ONE;
  assign hit_o    = active_i && (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !active_i || hit_o) begin
      // restart takes priority; a hit wraps to zero as well
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/stg_out_gate.sv
module stg_out_gate (
  input  logic hit_i,
  input  logic line_en_i,
  output logic trig_o,
  output logic line_o
);
  assign trig_o = hit_i;
  assign line_o = hit_i & line_en_i;
endmodule

// File: rtl/self_trig_gen.sv
module self_trig_gen #(
  parameter int unsigned PERIOD_W = stg_pkg::STG_PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                period_we_i,
  input  logic                line_test_en_i,
  output logic                trig_o,
  output logic                line_test_o,
  output logic                active_o
);
  logic [PERIOD_W-1:0] period_q;
  logic                active_q;
  logic                hit;

  stg_period_reg #(.W(PERIOD_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (period_we_i),
    .val_i    (period_i),
    .period_o (period_q),
    .active_o (active_q)
  );

  stg_tick_counter #(.W(PERIOD_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (period_we_i),
    .active_i  (active_q),
    .period_i  (period_q),
    .hit_o     (hit)
  );

  stg_out_gate u_gate (
    .hit_i     (hit),
    .line_en_i (line_test_en_i),
    .trig_o    (trig_o),
    .line_o    (line_test_o)
  );

  assign active_o = active_q;
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int unsigned W = stg_pkg::STG_PERIOD_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] period_i,
  input logic         period_we_i,
  input logic         line_test_en_i,
  input logic         trig_o,
  input logic         line_test_o,
  input logic         active_o,
  input logic [W-1:0] period_q
);
  localparam logic [W-1:0] ONE = W'(1);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> active_o);

  assert_active_follows_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_we_i |=> (active_o == ($past(period_i) != '0)));

  assert_every_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && period_q == ONE) |-> trig_o);

  assert_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && period_q > ONE && !(period_we_i && period_i == ONE)) |=> !trig_o);

  assert_line_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_test_o |-> (trig_o && line_test_en_i));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_we_i && period_i > ONE) |=> !trig_o);
endmodule

bind self_trig_gen stg_checker #(.W(PERIOD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .period_i       (period_i),
  .period_we_i    (period_we_i),
  .line_test_en_i (line_test_en_i),
  .trig_o         (trig_o),
  .line_test_o    (line_test_o),
  .active_o       (active_o),
  .period_q       (period_q)
);

// File: tb/tb_self_trig_gen.sv
module tb_self_trig_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 28;

  typedef struct packed {
    logic [W-1:0] per;
    logic         en;
    logic [7:0]   win;
    logic [7:0]   exp_cnt;
    logic [7:0]   exp_first;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{per: 28'd1,  en: 1'b1, win: 8'd8,  exp_cnt: 8'd8, exp_first: 8'd1},
    '{per: 28'd2,  en: 1'b0, win: 8'd10, exp_cnt: 8'd5, exp_first: 8'd2},
    '{per: 28'd3,  en: 1'b1, win: 8'd10, exp_cnt: 8'd3, exp_first: 8'd3},
    '{per: 28'd5,  en: 1'b1, win: 8'd12, exp_cnt: 8'd2, exp_first: 8'd5},
    '{per: 28'd7,  en: 1'b0, win: 8'd20, exp_cnt: 8'd2, exp_first: 8'd7},
    '{per: 28'd0,  en: 1'b1, win: 8'd10, exp_cnt: 8'd0, exp_first: 8'd0},
    '{per: 28'd16, en: 1'b1, win: 8'd40, exp_cnt: 8'd2, exp_first: 8'd16}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] period_i = '0;
  logic         period_we_i = 1'b0;
  logic         line_test_en_i = 1'b0;
  logic         trig_o, line_test_o, active_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  self_trig_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i),
    .period_we_i(period_we_i), .line_test_en_i(line_test_en_i),
    .trig_o(trig_o), .line_test_o(line_test_o), .active_o(active_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_period(input logic [W-1:0] v);
    @(negedge clk_i);
    period_i = v;
    period_we_i = 1'b1;
    @(posedge clk_i);
  endtask

  // samples at negedges; index j = edge number after the write edge
  task automatic observe(input int win, output int cnt, output int first, output int lcnt,
                         output int lbad);
    cnt = 0; first = 0; lcnt = 0; lbad = 0;
    for (int j = 1; j <= win; j++) begin
      @(negedge clk_i);
      period_we_i = 1'b0;
      if (trig_o) begin
        cnt++;
        if (first == 0) first = j;
      end
      if (line_test_o) lcnt++;
      if (line_test_o != (trig_o & line_test_en_i)) lbad++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int cnt, first, lcnt, lbad;
    #(CLK_PERIOD * 2 + 1);
    check("R1 trig in reset", int'(trig_o), 0);
    check("R1 active in reset", int'(active_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    observe(6, cnt, first, lcnt, lbad);
    check("R1 no strobe after reset", cnt, 0);
    check("R1 active after reset", int'(active_o), 0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      line_test_en_i = VECS[i].en;
      write_period(VECS[i].per);
      observe(int'(VECS[i].win), cnt, first, lcnt, lbad);
      check($sformatf("R4 count vec%0d", i), cnt, int'(VECS[i].exp_cnt));
      check($sformatf("R4 first vec%0d", i), first, int'(VECS[i].exp_first));
      check($sformatf("R6 line count vec%0d", i), lcnt,
            VECS[i].en ? int'(VECS[i].exp_cnt) : 0);
      check($sformatf("R6 line gate vec%0d", i), lbad, 0);
      check($sformatf("R3 active vec%0d", i), int'(active_o), int'(VECS[i].per != 0));
    end

    // R5: one-cycle width for P=2 (high/low alternation)
    write_period(28'd2);
    observe(9, cnt, first, lcnt, lbad);
    check("R5 width P=2", cnt, 4);

    // R7: rewrite same value mid-count
    write_period(28'd6);
    observe(4, cnt, first, lcnt, lbad);
    check("R7 no early strobe", cnt, 0);
    write_period(28'd6);
    observe(6, cnt, first, lcnt, lbad);
    check("R7 restart first", first, 6);
    check("R7 restart count", cnt, 1);

    // R8: write on a strobe cycle
    write_period(28'd4);
    observe(4, cnt, first, lcnt, lbad);
    check("R8 strobe seen", int'(trig_o), 1);
    period_i = 28'd3;
    period_we_i = 1'b1;
    @(posedge clk_i);
    observe(9, cnt, first, lcnt, lbad);
    check("R8 next after new period", first, 3);
    check("R8 count new period", cnt, 3);

    // R2: zero written mid-count
    write_period(28'd5);
    observe(2, cnt, first, lcnt, lbad);
    write_period(28'd0);
    observe(20, cnt, first, lcnt, lbad);
    check("R2 zero stops strobes", cnt, 0);
    check("R2 zero inactive", int'(active_o), 0);

    // R3: full-width value
    write_period(28'hFFFFFFF);
    observe(50, cnt, first, lcnt, lbad);
    check("R3 max active", int'(active_o), 1);
    check("R3 max no strobe", cnt, 0);

    // R1: reset mid-run
    write_period(28'd1);
    observe(2, cnt, first, lcnt, lbad);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset trig", int'(trig_o), 0);
    check("R1 async reset active", int'(active_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    observe(5, cnt, first, lcnt, lbad);
    check("R1 cleared period", cnt, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule